// File: doc/BRIEF.md
# Two-Channel Reloadable Down-Counter Timer

This peripheral holds two identical 32-bit down-counters behind a small register bus. A write request is taken in a single cycle. A read request returns its data one cycle later. Software sets a reload value and then starts a channel by writing its control register with the run and start bits both set. That write copies the reload value into the counter and restarts the channel's prescaler. The counter then decrements once every two input clocks. The step from zero is an underflow event. In auto-reload mode the counter refills from the reload value and keeps going, which gives periodic events. In one-shot mode it stays at zero and the run bit drops.

Each underflow sets a sticky flag and toggles a level bit. A channel's interrupt line is high while its flag and its interrupt enable are both set. Software clears the flag with a read-modify-write that leaves the flag bit at zero. A channel loaded with all ones in auto-reload mode acts as a free-running counter, and its count can be read at any time. One channel can serve as a free-running time base while the other produces events.

Top module: `dual_down_timer`

## Requirements
- R1: After reset, every register of both channels reads 0, and `irq`, `level_out` and `bus_rdata` are 0.
- R2: Address bit 4 selects the channel. Address bits 3:2 select the register within the channel: 0 is control, 1 is current count, 2 is the primary reload, 3 is the spare reload. Read data appears on `bus_rdata` in the cycle after the read request. The spare reload holds any written value and has no effect on counting.
- R3: Control bits are: 5 level, 4 auto-reload, 3 interrupt enable, 2 underflow flag, 1 run, 0 start. The start bit always reads 0. A control write with bits 1 and 0 both set loads the primary reload into the counter and restarts the prescaler.
- R4: A running counter decrements on every second clock. After a start with reload N, the underflow (the step from 0) lands on the 2(N+1)-th clock edge after the start write.
- R5: On underflow with auto-reload set, the counter reloads from the primary reload and keeps running. With all ones loaded it reads N-k after 2k clocks.
- R6: On underflow with auto-reload clear, the counter stays at 0 and the run bit clears.
- R7: The underflow flag is set by each underflow. A control write with bit 2 at 0 clears it, and a write with bit 2 at 1 leaves it unchanged. An underflow in the same cycle as a clearing write leaves the flag set.
- R8: `irq[i]` is high exactly while channel i's flag and interrupt enable are both set.
- R9: A control write with the run bit clear stops the counter and keeps its value. A later write with only the run bit set resumes from that value, and the prescaler phase is kept.
- R10: The level bit toggles on every underflow, and a control write sets it directly. `level_out[i]` carries it.
- R11: The channels are independent: activity in one never changes the other's registers or outputs.
- R12: Writing the current-count register loads the counter directly, unless a start or an underflow occurs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 5 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write request |
| bus_re | input | 1 | Read request |
| bus_rdata | output | 32 | Read data, valid the cycle after the request |
| irq | output | 2 | Per-channel interrupt level |
| level_out | output | 2 | Per-channel level bit |

## Verification
The hardest case to reach is a flag-clearing control write that lands on the same clock edge as an underflow. Both the prescaler phase and the count must be known to the cycle to produce it. The stimulus starts a one-shot channel with reload 1, which puts the underflow four edges after the start. It then issues the clearing write so that it lands on exactly that edge. It also checks exact count values after a stop and a resume in the middle of a prescaler period. This works because the bench derives every expected count from the number of edges since the start write.

// File: rtl/ddt_pkg.sv
package ddt_pkg;
  localparam int DATA_W   = 32;
  localparam int WIN_BITS = 4;

  typedef enum logic [1:0] {
    SEL_CTRL  = 2'd0,
    SEL_COUNT = 2'd1,
    SEL_RLD1  = 2'd2,
    SEL_RLD2  = 2'd3
  } reg_sel_e;

  localparam int B_START = 0;
  localparam int B_RUN   = 1;
  localparam int B_FLAG  = 2;
  localparam int B_IE    = 3;
  localparam int B_AUTO  = 4;
  localparam int B_LEVEL = 5;

  typedef struct packed {
    logic level;
    logic auto_rl;
    logic irq_en;
    logic flag;
    logic run;
  } ctrl_t;

  function automatic logic [DATA_W-1:0] ctrl_to_word(input ctrl_t c);
    logic [DATA_W-1:0] w;
    w          = '0;
    w[B_LEVEL] = c.level;
    w[B_AUTO]  = c.auto_rl;
    w[B_IE]    = c.irq_en;
    w[B_FLAG]  = c.flag;
    w[B_RUN]   = c.run;
    return w;
  endfunction

  function automatic logic is_start(input logic [DATA_W-1:0] w);
    return w[B_RUN] & w[B_START];
  endfunction

  function automatic logic [DATA_W-1:0] count_after_uf(input logic auto_rl,
                                                        input logic [DATA_W-1:0] rld);
    return auto_rl ? rld : '0;
  endfunction

  function automatic logic [DATA_W-1:0] count_step(input logic [DATA_W-1:0] cur);
    return cur - 1'b1;
  endfunction
endpackage

// File: rtl/ddt_prescaler.sv
module ddt_prescaler #(
  parameter int DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  output logic tick
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] phase_q;

  assign tick = run && (phase_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       phase_q <= '0;
    else if (restart) phase_q <= '0;
    else if (tick)    phase_q <= '0;
    else if (run)     phase_q <= phase_q + 1'b1;
  end
endmodule

// File: rtl/ddt_channel.sv
module ddt_channel
  import ddt_pkg::*;
#(
  parameter int PRESCALE = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctrl,
  input  logic              wr_count,
  input  logic              wr_rld1,
  input  logic              wr_rld2,
  input  logic [DATA_W-1:0] wdata,
  output ctrl_t             ctrl_q,
  output logic [DATA_W-1:0] count_q,
  output logic [DATA_W-1:0] rld1_q,
  output logic [DATA_W-1:0] rld2_q,
  output logic              tick_o,
  output logic              uf_evt_o,
  output logic              start_o,
  output logic              irq_o
);
  logic tick;
  logic start;
  logic uf_evt;

  assign start  = wr_ctrl && is_start(wdata);
  assign uf_evt = tick && (count_q == '0) && !start;

  ddt_prescaler #(.DIV(PRESCALE)) u_presc (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (ctrl_q.run),
    .restart (start),
    .tick    (tick)
  );

  // control / status register: hardware events override the concurrent write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else begin
      if (wr_ctrl) begin
        ctrl_q.level   <= wdata[B_LEVEL];
        ctrl_q.auto_rl <= wdata[B_AUTO];
        ctrl_q.irq_en  <= wdata[B_IE];
        ctrl_q.flag    <= ctrl_q.flag & wdata[B_FLAG];
        ctrl_q.run     <= wdata[B_RUN];
      end
      if (uf_evt) begin
        ctrl_q.flag  <= 1'b1;
        ctrl_q.level <= ~ctrl_q.level;
        if (!ctrl_q.auto_rl) ctrl_q.run <= 1'b0;
      end
    end
  end

  // counter: start > underflow > direct write > decrement
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        count_q <= '0;
    else if (start)    count_q <= rld1_q;
    else if (uf_evt)   count_q <= count_after_uf(ctrl_q.auto_rl, rld1_q);
    else if (wr_count) count_q <= wdata;
    else if (tick)     count_q <= count_step(count_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rld1_q <= '0;
      rld2_q <= '0;
    end else begin
      if (wr_rld1) rld1_q <= wdata;
      if (wr_rld2) rld2_q <= wdata;
    end
  end

  assign tick_o   = tick;
  assign uf_evt_o = uf_evt;
  assign start_o  = start;
  assign irq_o    = ctrl_q.flag & ctrl_q.irq_en;
endmodule

// File: rtl/dual_down_timer.sv
module dual_down_timer
  import ddt_pkg::*;
#(
  parameter  int NUM_CH   = 2,
  parameter  int PRESCALE = 2,
  localparam int CH_W     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int ADDR_W   = WIN_BITS + CH_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NUM_CH-1:0] irq,
  output logic [NUM_CH-1:0] level_out
);
  logic [CH_W-1:0] ch_idx;
  reg_sel_e        sel;
  wire             unused_lsb = ^bus_addr[1:0];

  assign ch_idx = bus_addr[ADDR_W-1:WIN_BITS];
  assign sel    = reg_sel_e'(bus_addr[WIN_BITS-1:2]);

  // per-channel named events for the checker
  logic [NUM_CH-1:0]             ch_tick, ch_uf_evt, ch_start, ch_cnt_wr, ch_ctrl_wr;
  logic [NUM_CH-1:0]             ch_run, ch_auto, ch_flag, ch_level;
  logic [NUM_CH-1:0][DATA_W-1:0] ch_count, ch_rld1, ch_rld2;
  logic [NUM_CH-1:0][DATA_W-1:0] ch_word;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic  hit;
    ctrl_t ctl;

    assign hit           = bus_we && (ch_idx == CH_W'(i));
    assign ch_ctrl_wr[i] = hit && (sel == SEL_CTRL);
    assign ch_cnt_wr[i]  = hit && (sel == SEL_COUNT);

    ddt_channel #(.PRESCALE(PRESCALE)) u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_ctrl  (ch_ctrl_wr[i]),
      .wr_count (ch_cnt_wr[i]),
      .wr_rld1  (hit && (sel == SEL_RLD1)),
      .wr_rld2  (hit && (sel == SEL_RLD2)),
      .wdata    (bus_wdata),
      .ctrl_q   (ctl),
      .count_q  (ch_count[i]),
      .rld1_q   (ch_rld1[i]),
      .rld2_q   (ch_rld2[i]),
      .tick_o   (ch_tick[i]),
      .uf_evt_o (ch_uf_evt[i]),
      .start_o  (ch_start[i]),
      .irq_o    (irq[i])
    );

    assign ch_run[i]    = ctl.run;
    assign ch_auto[i]   = ctl.auto_rl;
    assign ch_flag[i]   = ctl.flag;
    assign ch_level[i]  = ctl.level;
    assign level_out[i] = ctl.level;

    always_comb begin
      unique case (sel)
        SEL_CTRL:  ch_word[i] = ctrl_to_word(ctl);
        SEL_COUNT: ch_word[i] = ch_count[i];
        SEL_RLD1:  ch_word[i] = ch_rld1[i];
        default:   ch_word[i] = ch_rld2[i];
      endcase
    end
  end

  logic [DATA_W-1:0] rd_word;
  always_comb begin
    rd_word = '0;
    for (int i = 0; i < NUM_CH; i++)
      if (ch_idx == CH_W'(i)) rd_word = ch_word[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_re) bus_rdata <= rd_word;
  end
endmodule

// File: rtl/ddt_checker.sv
module ddt_checker
  import ddt_pkg::*;
#(
  parameter int NUM_CH = 2
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic [NUM_CH-1:0]            tick,
  input logic [NUM_CH-1:0]            uf_evt,
  input logic [NUM_CH-1:0]            start,
  input logic [NUM_CH-1:0]            cnt_wr,
  input logic [NUM_CH-1:0]            run,
  input logic [NUM_CH-1:0]            auto_rl,
  input logic [NUM_CH-1:0]            flag,
  input logic [NUM_CH-1:0]            level,
  input logic [NUM_CH-1:0]            irq,
  input logic [NUM_CH-1:0][DATA_W-1:0] count,
  input logic [NUM_CH-1:0][DATA_W-1:0] rld1
);
  for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
    // R4
    step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick[i] && count[i] != '0 && !start[i] && !cnt_wr[i])
        |=> count[i] == $past(count[i]) - 1'b1);

    // R5
    auto_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (uf_evt[i] && auto_rl[i]) |=> count[i] == $past(rld1[i]));

    // R6
    one_shot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (uf_evt[i] && !auto_rl[i]) |=> (!run[i] && count[i] == '0));

    // R7
    flag_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag[i]) |-> $past(uf_evt[i]));

    // R7
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      uf_evt[i] |=> flag[i]);

    // R8
    irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq[i] |-> flag[i]);

    // R9
    stopped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!run[i] && !cnt_wr[i] && !start[i]) |=> $stable(count[i]));

    // R10
    level_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      uf_evt[i] |=> level[i] != $past(level[i]));
  end
endmodule

bind dual_down_timer ddt_checker #(.NUM_CH(NUM_CH)) u_ddt_checker (
  .clk     (clk),
  .rst_n   (rst_n),
  .tick    (ch_tick),
  .uf_evt  (ch_uf_evt),
  .start   (ch_start),
  .cnt_wr  (ch_cnt_wr),
  .run     (ch_run),
  .auto_rl (ch_auto),
  .flag    (ch_flag),
  .level   (ch_level),
  .irq     (irq),
  .count   (ch_count),
  .rld1    (ch_rld1)
);

// File: tb/dual_down_timer_test.sv
module dual_down_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_we = 1'b0;
  logic        bus_re = 1'b0;
  logic [31:0] bus_rdata;
  logic [1:0]  irq;
  logic [1:0]  level_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } exp_item_t;
  exp_item_t exp_q[$];
  logic re_seen = 1'b0;

  always #5 clk = ~clk;

  dual_down_timer uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_we    (bus_we),
    .bus_re    (bus_re),
    .bus_rdata (bus_rdata),
    .irq       (irq),
    .level_out (level_out)
  );

  // register addresses: channel in bit 4, register in bits 3:2
  localparam logic [4:0] C0_CTRL = 5'h00, C0_CNT = 5'h04, C0_RLD = 5'h08, C0_RLD2 = 5'h0C;
  localparam logic [4:0] C1_CTRL = 5'h10, C1_CNT = 5'h14, C1_RLD = 5'h18, C1_RLD2 = 5'h1C;

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, input logic [31:0] exp, input string tag);
    exp_item_t it;
    it.exp = exp; it.tag = tag;
    exp_q.push_back(it);
    bus_addr = a; bus_re = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_re = 1'b0;
  endtask

  // monitor: compares read data with the scoreboard one cycle after a request
  always @(posedge clk) re_seen <= bus_re;
  always @(negedge clk) begin
    if (re_seen) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL scoreboard: unexpected read %h expected none", bus_rdata);
      end else begin
        exp_item_t it;
        it = exp_q.pop_front();
        check(bus_rdata, it.exp, it.tag);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check({30'd0, irq}, 32'd0, "R1 irq after reset");
    check({30'd0, level_out}, 32'd0, "R1 level after reset");
    check(bus_rdata, 32'd0, "R1 rdata after reset");
    rd(C0_CTRL, 32'h0, "R1 ch0 ctrl");
    rd(C1_CNT,  32'h0, "R1 ch1 count");
    rd(C0_RLD,  32'h0, "R1 ch0 reload");
    rd(C1_RLD2, 32'h0, "R1 ch1 spare reload");

    // R2 register map and readback
    wr(C1_RLD2, 32'hA5A5_0001);
    wr(C0_RLD2, 32'h0000_0007);
    rd(C1_RLD2, 32'hA5A5_0001, "R2 ch1 spare reload");
    rd(C0_RLD2, 32'h0000_0007, "R2 ch0 spare reload");

    // R4 R6 R8 one-shot on ch0, reload 3 -> underflow on edge 8
    wr(C0_RLD, 32'd3);
    wr(C0_CTRL, 32'h0B);
    repeat (7) @(negedge clk);
    check({31'd0, irq[0]}, 32'd0, "R4 no underflow before edge 8");
    @(negedge clk);
    check({31'd0, irq[0]}, 32'd1, "R4 R8 underflow on edge 8");
    check({31'd0, irq[1]}, 32'd0, "R11 ch1 irq untouched");
    check({31'd0, level_out[0]}, 32'd1, "R10 level toggled");
    rd(C0_CTRL, 32'h2C, "R3 R6 ch0 ctrl after one-shot");
    rd(C0_CNT, 32'd0, "R6 ch0 count stays 0");

    // R7 flag write semantics
    wr(C0_CTRL, 32'h0C);
    rd(C0_CTRL, 32'h0C, "R7 writing 1 keeps flag, R10 level written");
    wr(C0_CTRL, 32'h08);
    check({31'd0, irq[0]}, 32'd0, "R8 irq low after flag clear");
    rd(C0_CTRL, 32'h08, "R7 flag cleared");
    wr(C0_CTRL, 32'h0C);
    rd(C0_CTRL, 32'h08, "R7 writing 1 cannot set flag");

    // R5 auto-reload on ch1, reload 2 -> underflows on edges 6 and 12
    wr(C1_RLD, 32'd2);
    wr(C1_CTRL, 32'h1B);
    repeat (5) @(negedge clk);
    check({31'd0, irq[1]}, 32'd0, "R5 no underflow before edge 6");
    @(negedge clk);
    check({31'd0, irq[1]}, 32'd1, "R5 first underflow edge 6");
    wr(C1_CTRL, 32'h1A);
    check({31'd0, irq[1]}, 32'd0, "R7 R8 clear keeps counting");
    repeat (4) @(negedge clk);
    check({31'd0, irq[1]}, 32'd0, "R5 no underflow before edge 12");
    @(negedge clk);
    check({31'd0, irq[1]}, 32'd1, "R5 periodic underflow edge 12");

    // R9 stop keeps value, resume keeps prescaler phase
    wr(C1_CTRL, 32'h00);
    rd(C1_CNT, 32'd2, "R9 stopped value");
    repeat (10) @(negedge clk);
    rd(C1_CNT, 32'd2, "R9 value holds while stopped");
    wr(C1_CTRL, 32'h02);
    rd(C1_CNT, 32'd2, "R9 resume from held value");
    repeat (2) @(negedge clk);
    rd(C1_CNT, 32'd0, "R9 resume continues with kept phase");

    // R12 direct count write on stopped ch0
    wr(C0_CNT, 32'h0000_1234);
    rd(C0_CNT, 32'h0000_1234, "R12 count write");

    // R5 free-running ch0
    wr(C0_RLD, 32'hFFFF_FFFF);
    wr(C0_CTRL, 32'h13);
    rd(C0_CNT, 32'hFFFF_FFFF, "R3 start loads reload");
    repeat (10) @(negedge clk);
    rd(C0_CNT, 32'hFFFF_FFFA, "R5 free-running count");
    rd(C0_CTRL, 32'h12, "R3 start bit reads 0");
    rd(C1_RLD2, 32'hA5A5_0001, "R2 spare reload unchanged");
    rd(C1_CNT, 32'd0, "R6 R11 ch1 one-shot ended at 0");

    // R7 underflow coincident with a clearing write: flag stays set
    wr(C1_CTRL, 32'h00);
    wr(C1_RLD, 32'd1);
    wr(C1_CTRL, 32'h0B);
    repeat (3) @(negedge clk);
    wr(C1_CTRL, 32'h0A);
    check({31'd0, irq[1]}, 32'd1, "R7 R8 set wins over clear");
    rd(C1_CTRL, 32'h2C, "R7 R6 ctrl after coincident write");

    @(negedge clk);
    check(exp_q.size(), 32'd0, "scoreboard drained");
    done = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule